// File: doc/BRIEF.md
# Delayed Transaction Queue Controller

This block sits between the initiator side and the target side of a bridge that joins two independent buses, and it handles split transactions there. Reads of every kind and the non-posted writes (I/O and configuration) are not passed straight through. The first attempt is answered with a retry and is recorded in a small queue. The controller then runs the recorded request on the target side. The completion that comes back, either read data or write status, is held in that entry until the initiator repeats the same request. The repeat then receives the stored result, and the entry is released.

Each entry completes on its own. The target side may return completions in any order, and queued entries are offered to the target side in rotation, so no entry can hold up another. Writes are kept apart at all times: two writes that differ in any field occupy separate entries and reach the target separately. Two independent posted-write lanes, one for each direction, pass every write beat through as a beat of its own.

Both sides use a simplified request/response handshake rather than full bus signalling. Arbitration, parity and clock-domain crossing are handled elsewhere.

Top module: `dtq_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, ini_rsp_valid, tgt_req_valid, dn_pw_out_valid and up_pw_out_valid are 0.
- R2: A request on the initiator side (ini_req_valid=1) gets a response one cycle later (ini_rsp_valid=1). A request that matches no entry, while an entry is free, is answered with ini_rsp_retry=1 and stored in the lowest-numbered free entry. That entry is then presented on the target port with the same cmd, addr, be and wdata, and tgt_req_tag set to the entry index.
- R3: When all DEPTH entries are in use, a new request that matches none of them is answered with a retry and is not stored, so no additional target request appears.
- R4: A repeat that matches an entry whose completion has not yet arrived is answered with a retry. This includes a completion that arrives in the same cycle as the repeat.
- R5: A repeat that matches a completed entry is answered with ini_rsp_retry=0 and ini_rsp_data equal to the stored completion data, and the entry is released. A further identical request is then treated as new.
- R6: A repeat matches an entry only if cmd, addr and be are all equal, and also wdata for write commands. For reads, wdata is not compared. Command codes are 0 memory read, 1 I/O read, 2 configuration read, 3 I/O write and 4 configuration write.
- R7: Completions (tgt_cpl_valid with tgt_cpl_tag) are accepted for issued entries in any order. Each entry returns only the data delivered with its own tag.
- R8: An entry is issued when tgt_req_valid and tgt_req_ready are both high. Entries that are waiting are granted in round-robin order, starting at the index after the last grant.
- R9: Writes are never combined, merged or collapsed. Writes to the same address that differ in be or wdata each become a separate target request with their own be and wdata.
- R10: Each beat on a posted-write input lane appears exactly once on that lane's output one cycle later, with unchanged addr, be and data. This holds for back-to-back beats to the same address.
- R11: The downstream and upstream posted-write lanes are independent and may both carry a beat in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ini_req_valid | input | 1 | Initiator-side request present |
| ini_req_cmd | input | 3 | Command code (see R6) |
| ini_req_addr | input | ADDR_W | Request address |
| ini_req_be | input | BE_W | Byte enables |
| ini_req_wdata | input | DATA_W | Write data |
| ini_rsp_valid | output | 1 | Response present |
| ini_rsp_retry | output | 1 | 1 = retry, 0 = completed |
| ini_rsp_data | output | DATA_W | Read data or write status |
| tgt_req_valid | output | 1 | A queued entry is offered |
| tgt_req_ready | input | 1 | Target side accepts the offered entry |
| tgt_req_tag | output | TAG_W | Entry index of the offer |
| tgt_req_cmd | output | 3 | Command of the offer |
| tgt_req_addr | output | ADDR_W | Address of the offer |
| tgt_req_be | output | BE_W | Byte enables of the offer |
| tgt_req_wdata | output | DATA_W | Write data of the offer |
| tgt_cpl_valid | input | 1 | Completion present |
| tgt_cpl_tag | input | TAG_W | Entry the completion belongs to |
| tgt_cpl_data | input | DATA_W | Read data or write status |
| dn_pw_in_valid | input | 1 | Downstream posted write beat in |
| dn_pw_in_addr | input | ADDR_W | Its address |
| dn_pw_in_be | input | BE_W | Its byte enables |
| dn_pw_in_data | input | DATA_W | Its data |
| dn_pw_out_valid | output | 1 | Downstream posted write beat out |
| dn_pw_out_addr | output | ADDR_W | Its address |
| dn_pw_out_be | output | BE_W | Its byte enables |
| dn_pw_out_data | output | DATA_W | Its data |
| up_pw_in_valid | input | 1 | Upstream posted write beat in |
| up_pw_in_addr | input | ADDR_W | Its address |
| up_pw_in_be | input | BE_W | Its byte enables |
| up_pw_in_data | input | DATA_W | Its data |
| up_pw_out_valid | output | 1 | Upstream posted write beat out |
| up_pw_out_addr | output | ADDR_W | Its address |
| up_pw_out_be | output | BE_W | Its byte enables |
| up_pw_out_data | output | DATA_W | Its data |

## Verification
Two functions can fall into the same cycle: a completion returning for an entry, and the initiator repeating the request held in that same entry. The bench drives tgt_cpl_valid and a matching ini_req_valid on the same edge. The repeat must be answered with a retry, because it is compared against the state before the edge, and the next repeat must then receive the completion data. Posted beats on both lanes are also driven in the same cycle, and each lane's output is checked on its own.

// File: rtl/dtq_pkg.sv
// Package: command codes, entry states and helpers shared by the
// delayed transaction queue modules.
package dtq_pkg;

    typedef enum logic [2:0] {
        CMD_MEM_RD = 3'd0,
        CMD_IO_RD  = 3'd1,
        CMD_CFG_RD = 3'd2,
        CMD_IO_WR  = 3'd3,
        CMD_CFG_WR = 3'd4
    } dtq_cmd_e;

    typedef enum logic [1:0] {
        ENT_FREE   = 2'd0,
        ENT_QUEUED = 2'd1,
        ENT_ISSUED = 2'd2,
        ENT_DONE   = 2'd3
    } dtq_state_e;

    // True for the non-posted write commands whose data takes part in matching.
    function automatic logic cmd_is_write(input logic [2:0] cmd);
        return (cmd == CMD_IO_WR) || (cmd == CMD_CFG_WR);
    endfunction

endpackage

// File: rtl/dtq_entry.sv
// One queue entry. It holds the recorded request and, once the target side
// completes it, the returned data. It reports whether the incoming request
// is a repeat of the one it holds.
// Assumes: alloc_i only when FREE, issue_i only when QUEUED,
// cpl_i only when ISSUED, release_i only when DONE (the parent gates these).
module dtq_entry
    import dtq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              issue_i,
    input  logic              cpl_i,
    input  logic              release_i,
    input  logic [2:0]        in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] cpl_data_i,
    output dtq_state_e        state_o,
    output logic [2:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BE_W-1:0]   be_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              hit_o
);

    // Lifecycle of the entry: free -> queued -> issued -> done -> free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= ENT_FREE;
        end else if (alloc_i) begin
            state_o <= ENT_QUEUED;
        end else if (issue_i) begin
            state_o <= ENT_ISSUED;
        end else if (cpl_i) begin
            state_o <= ENT_DONE;
        end else if (release_i) begin
            state_o <= ENT_FREE;
        end
    end

    // Request fields are captured at allocation, completion data on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o   <= '0;
            addr_o  <= '0;
            be_o    <= '0;
            wdata_o <= '0;
            rdata_o <= '0;
        end else begin
            if (alloc_i) begin
                cmd_o   <= in_cmd;
                addr_o  <= in_addr;
                be_o    <= in_be;
                wdata_o <= in_wdata;
            end
            if (cpl_i) begin
                rdata_o <= cpl_data_i;
            end
        end
    end

    // Repeat detection: all request fields equal, and write data only for writes.
    always_comb begin
        hit_o = (state_o != ENT_FREE) && (cmd_o == in_cmd) && (addr_o == in_addr)
             && (be_o == in_be) && (!cmd_is_write(cmd_o) || (wdata_o == in_wdata));
    end

endmodule

// File: rtl/dtq_rr_arb.sv
// Round-robin arbiter. It grants the first requester at or after the
// pointer, and the pointer moves past the winner when a grant is taken.
// Assumes: fire_i only in a cycle where some request is present.
module dtq_rr_arb #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             fire_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] grant_idx_o
);

    logic [IDX_W-1:0] ptr_q;

    // Search from the pointer for the first requester.
    always_comb begin
        logic found;
        found       = 1'b0;
        grant_o     = '0;
        grant_idx_o = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (!found && req_i[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                grant_idx_o  = IDX_W'(idx);
            end
        end
    end

    // Advance the pointer to the index just past the accepted grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fire_i) begin
            ptr_q <= (int'(grant_idx_o) == N - 1) ? '0 : grant_idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/dtq_pw_lane.sv
// Posted-write lane. It moves each input beat to the output one cycle
// later, unchanged and on its own, with no combining of beats.
// Assumes: the sink accepts every beat.
module dtq_pw_lane #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    output logic [DATA_W-1:0] out_data
);

    // One register stage per beat; a valid beat always replaces the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_be    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= in_addr;
                out_be   <= in_be;
                out_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/dtq_ctrl.sv
// Delayed transaction queue controller, top level. It retries and records
// new non-posted requests, offers the recorded entries to the target side in
// round-robin order, stores their completions, and returns each completion
// when its request is repeated. It also carries one posted-write lane in
// each direction.
// Assumes: at most one initiator request per cycle, and completions only
// for entries that have been issued.
module dtq_ctrl
    import dtq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ini_req_valid,
    input  logic [2:0]        ini_req_cmd,
    input  logic [ADDR_W-1:0] ini_req_addr,
    input  logic [BE_W-1:0]   ini_req_be,
    input  logic [DATA_W-1:0] ini_req_wdata,
    output logic              ini_rsp_valid,
    output logic              ini_rsp_retry,
    output logic [DATA_W-1:0] ini_rsp_data,
    output logic              tgt_req_valid,
    input  logic              tgt_req_ready,
    output logic [TAG_W-1:0]  tgt_req_tag,
    output logic [2:0]        tgt_req_cmd,
    output logic [ADDR_W-1:0] tgt_req_addr,
    output logic [BE_W-1:0]   tgt_req_be,
    output logic [DATA_W-1:0] tgt_req_wdata,
    input  logic              tgt_cpl_valid,
    input  logic [TAG_W-1:0]  tgt_cpl_tag,
    input  logic [DATA_W-1:0] tgt_cpl_data,
    input  logic              dn_pw_in_valid,
    input  logic [ADDR_W-1:0] dn_pw_in_addr,
    input  logic [BE_W-1:0]   dn_pw_in_be,
    input  logic [DATA_W-1:0] dn_pw_in_data,
    output logic              dn_pw_out_valid,
    output logic [ADDR_W-1:0] dn_pw_out_addr,
    output logic [BE_W-1:0]   dn_pw_out_be,
    output logic [DATA_W-1:0] dn_pw_out_data,
    input  logic              up_pw_in_valid,
    input  logic [ADDR_W-1:0] up_pw_in_addr,
    input  logic [BE_W-1:0]   up_pw_in_be,
    input  logic [DATA_W-1:0] up_pw_in_data,
    output logic              up_pw_out_valid,
    output logic [ADDR_W-1:0] up_pw_out_addr,
    output logic [BE_W-1:0]   up_pw_out_be,
    output logic [DATA_W-1:0] up_pw_out_data
);

    dtq_state_e        ent_state [DEPTH];
    logic [2:0]        ent_cmd   [DEPTH];
    logic [ADDR_W-1:0] ent_addr  [DEPTH];
    logic [BE_W-1:0]   ent_be    [DEPTH];
    logic [DATA_W-1:0] ent_wdata [DEPTH];
    logic [DATA_W-1:0] ent_rdata [DEPTH];
    logic [DEPTH-1:0]  hit_vec, queued_vec, free_vec;
    logic [DEPTH-1:0]  alloc_vec, issue_vec, cpl_vec, release_vec;
    logic [DEPTH-1:0]  grant_vec;
    logic [TAG_W-1:0]  grant_idx, free_idx;
    logic              hit_any, hit_done, tgt_fire;
    logic [DATA_W-1:0] hit_rdata;

    // One entry per queue slot, each with its own control strobes.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        dtq_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_vec[i]),
            .issue_i   (issue_vec[i]),
            .cpl_i     (cpl_vec[i]),
            .release_i (release_vec[i]),
            .in_cmd    (ini_req_cmd),
            .in_addr   (ini_req_addr),
            .in_be     (ini_req_be),
            .in_wdata  (ini_req_wdata),
            .cpl_data_i(tgt_cpl_data),
            .state_o   (ent_state[i]),
            .cmd_o     (ent_cmd[i]),
            .addr_o    (ent_addr[i]),
            .be_o      (ent_be[i]),
            .wdata_o   (ent_wdata[i]),
            .rdata_o   (ent_rdata[i]),
            .hit_o     (hit_vec[i])
        );
        assign queued_vec[i]  = (ent_state[i] == ENT_QUEUED);
        assign free_vec[i]    = (ent_state[i] == ENT_FREE);
        assign issue_vec[i]   = grant_vec[i] && tgt_req_ready;
        assign cpl_vec[i]     = tgt_cpl_valid && (tgt_cpl_tag == TAG_W'(i))
                             && (ent_state[i] == ENT_ISSUED);
        assign release_vec[i] = ini_req_valid && hit_vec[i] && (ent_state[i] == ENT_DONE);
        assign alloc_vec[i]   = ini_req_valid && !hit_any && (|free_vec)
                             && (free_idx == TAG_W'(i));
    end

    // Classify the incoming request and pick the lowest free slot.
    always_comb begin
        hit_any   = |hit_vec;
        hit_done  = |release_vec;
        hit_rdata = '0;
        free_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = TAG_W'(i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (release_vec[i]) hit_rdata = ent_rdata[i];
        end
    end

    dtq_rr_arb #(.N(DEPTH)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (queued_vec),
        .fire_i     (tgt_fire),
        .grant_o    (grant_vec),
        .grant_idx_o(grant_idx)
    );

    // Offer the granted entry's fields on the target port.
    always_comb begin
        tgt_req_valid = |queued_vec;
        tgt_fire      = tgt_req_valid && tgt_req_ready;
        tgt_req_tag   = grant_idx;
        tgt_req_cmd   = ent_cmd[grant_idx];
        tgt_req_addr  = ent_addr[grant_idx];
        tgt_req_be    = ent_be[grant_idx];
        tgt_req_wdata = ent_wdata[grant_idx];
    end

    // Register the initiator-side answer one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ini_rsp_valid <= 1'b0;
            ini_rsp_retry <= 1'b0;
            ini_rsp_data  <= '0;
        end else begin
            ini_rsp_valid <= ini_req_valid;
            ini_rsp_retry <= ini_req_valid && !hit_done;
            ini_rsp_data  <= (ini_req_valid && hit_done) ? hit_rdata : '0;
        end
    end

    dtq_pw_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pw_dn (
        .clk(clk), .rst_n(rst_n),
        .in_valid(dn_pw_in_valid), .in_addr(dn_pw_in_addr),
        .in_be(dn_pw_in_be), .in_data(dn_pw_in_data),
        .out_valid(dn_pw_out_valid), .out_addr(dn_pw_out_addr),
        .out_be(dn_pw_out_be), .out_data(dn_pw_out_data)
    );

    dtq_pw_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pw_up (
        .clk(clk), .rst_n(rst_n),
        .in_valid(up_pw_in_valid), .in_addr(up_pw_in_addr),
        .in_be(up_pw_in_be), .in_data(up_pw_in_data),
        .out_valid(up_pw_out_valid), .out_addr(up_pw_out_addr),
        .out_be(up_pw_out_be), .out_data(up_pw_out_data)
    );

endmodule

// File: rtl/dtq_ctrl_chk.sv
// Checker for dtq_ctrl, attached by bind. It observes the ports and the
// per-entry repeat-detection vector.
module dtq_ctrl_chk #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ini_req_valid,
    input logic              ini_rsp_valid,
    input logic              ini_rsp_retry,
    input logic              tgt_req_valid,
    input logic [DEPTH-1:0]  hit_vec,
    input logic              dn_pw_in_valid,
    input logic [DATA_W-1:0] dn_pw_in_data,
    input logic              dn_pw_out_valid,
    input logic [DATA_W-1:0] dn_pw_out_data,
    input logic              up_pw_in_valid,
    input logic [DATA_W-1:0] up_pw_in_data,
    input logic              up_pw_out_valid,
    input logic [DATA_W-1:0] up_pw_out_data
);

    // R1: outputs are idle in the cycle after reset is sampled.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !ini_rsp_valid && !tgt_req_valid && !dn_pw_out_valid && !up_pw_out_valid);

    // R2: every request gets exactly one response one cycle later.
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ini_req_valid |=> ini_rsp_valid);
    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ini_req_valid |=> !ini_rsp_valid && !ini_rsp_retry);

    // R6: a request never matches more than one entry.
    p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ini_req_valid |-> $onehot0(hit_vec));

    // R10: downstream beat comes out next cycle with the same data.
    p_pw_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_pw_in_valid |=> dn_pw_out_valid && (dn_pw_out_data == $past(dn_pw_in_data)));

    // R11: upstream lane behaves the same, independently.
    p_pw_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        up_pw_in_valid |=> up_pw_out_valid && (up_pw_out_data == $past(up_pw_in_data)));

endmodule

bind dtq_ctrl dtq_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ini_req_valid  (ini_req_valid),
    .ini_rsp_valid  (ini_rsp_valid),
    .ini_rsp_retry  (ini_rsp_retry),
    .tgt_req_valid  (tgt_req_valid),
    .hit_vec        (hit_vec),
    .dn_pw_in_valid (dn_pw_in_valid),
    .dn_pw_in_data  (dn_pw_in_data),
    .dn_pw_out_valid(dn_pw_out_valid),
    .dn_pw_out_data (dn_pw_out_data),
    .up_pw_in_valid (up_pw_in_valid),
    .up_pw_in_data  (up_pw_in_data),
    .up_pw_out_valid(up_pw_out_valid),
    .up_pw_out_data (up_pw_out_data)
);

// File: tb/tb_dtq_ctrl.sv
// Directed bench for dtq_ctrl: one task per scenario, each checking itself.
// Inputs change on the falling edge and outputs are sampled on the falling edge.
module tb_dtq_ctrl;
    localparam int AW = 32, DW = 32, BW = 4, TW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ini_req_valid = 0; logic [2:0] ini_req_cmd = 0;
    logic [AW-1:0] ini_req_addr = 0; logic [BW-1:0] ini_req_be = 0; logic [DW-1:0] ini_req_wdata = 0;
    logic ini_rsp_valid, ini_rsp_retry; logic [DW-1:0] ini_rsp_data;
    logic tgt_req_valid, tgt_req_ready = 0; logic [TW-1:0] tgt_req_tag; logic [2:0] tgt_req_cmd;
    logic [AW-1:0] tgt_req_addr; logic [BW-1:0] tgt_req_be; logic [DW-1:0] tgt_req_wdata;
    logic tgt_cpl_valid = 0; logic [TW-1:0] tgt_cpl_tag = 0; logic [DW-1:0] tgt_cpl_data = 0;
    logic dn_in_v = 0, up_in_v = 0; logic [AW-1:0] dn_in_a = 0, up_in_a = 0;
    logic [BW-1:0] dn_in_b = 0, up_in_b = 0; logic [DW-1:0] dn_in_d = 0, up_in_d = 0;
    logic dn_out_v, up_out_v; logic [AW-1:0] dn_out_a, up_out_a;
    logic [BW-1:0] dn_out_b, up_out_b; logic [DW-1:0] dn_out_d, up_out_d;

    int total = 0, bad = 0;

    dtq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .ini_req_valid(ini_req_valid), .ini_req_cmd(ini_req_cmd), .ini_req_addr(ini_req_addr),
        .ini_req_be(ini_req_be), .ini_req_wdata(ini_req_wdata),
        .ini_rsp_valid(ini_rsp_valid), .ini_rsp_retry(ini_rsp_retry), .ini_rsp_data(ini_rsp_data),
        .tgt_req_valid(tgt_req_valid), .tgt_req_ready(tgt_req_ready), .tgt_req_tag(tgt_req_tag),
        .tgt_req_cmd(tgt_req_cmd), .tgt_req_addr(tgt_req_addr), .tgt_req_be(tgt_req_be),
        .tgt_req_wdata(tgt_req_wdata),
        .tgt_cpl_valid(tgt_cpl_valid), .tgt_cpl_tag(tgt_cpl_tag), .tgt_cpl_data(tgt_cpl_data),
        .dn_pw_in_valid(dn_in_v), .dn_pw_in_addr(dn_in_a), .dn_pw_in_be(dn_in_b), .dn_pw_in_data(dn_in_d),
        .dn_pw_out_valid(dn_out_v), .dn_pw_out_addr(dn_out_a), .dn_pw_out_be(dn_out_b), .dn_pw_out_data(dn_out_d),
        .up_pw_in_valid(up_in_v), .up_pw_in_addr(up_in_a), .up_pw_in_be(up_in_b), .up_pw_in_data(up_in_d),
        .up_pw_out_valid(up_out_v), .up_pw_out_addr(up_out_a), .up_pw_out_be(up_out_b), .up_pw_out_data(up_out_d)
    );

    always #5 clk = ~clk;

    // Record one check; print a FAIL line with actual and expected on mismatch.
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one initiator request; return the registered response.
    task automatic send(input logic [2:0] c, input logic [AW-1:0] a, input logic [BW-1:0] b,
                        input logic [DW-1:0] w, output logic retry, output logic [DW-1:0] d);
        ini_req_valid = 1; ini_req_cmd = c; ini_req_addr = a; ini_req_be = b; ini_req_wdata = w;
        @(negedge clk);
        ini_req_valid = 0;
        check(ini_rsp_valid === 1'b1, "R2 response valid", ini_rsp_valid, 1);
        retry = ini_rsp_retry; d = ini_rsp_data;
    endtask

    // Accept one target-side offer and return its fields.
    task automatic take(output logic [TW-1:0] t, output logic [2:0] c, output logic [AW-1:0] a,
                        output logic [BW-1:0] b, output logic [DW-1:0] w);
        while (!tgt_req_valid) @(negedge clk);
        t = tgt_req_tag; c = tgt_req_cmd; a = tgt_req_addr; b = tgt_req_be; w = tgt_req_wdata;
        tgt_req_ready = 1;
        @(negedge clk);
        tgt_req_ready = 0;
    endtask

    // Return one completion for a tag.
    task automatic complete(input logic [TW-1:0] t, input logic [DW-1:0] d);
        tgt_cpl_valid = 1; tgt_cpl_tag = t; tgt_cpl_data = d;
        @(negedge clk);
        tgt_cpl_valid = 0;
    endtask

    task automatic t_reset();
        check(!ini_rsp_valid && !tgt_req_valid && !dn_out_v && !up_out_v, "R1 idle after reset",
              {ini_rsp_valid, tgt_req_valid, dn_out_v, up_out_v}, 0);
    endtask

    // Basic flow: retry, offer, retry on pending, data on completion, freed.
    task automatic t_basic();
        logic r; logic [DW-1:0] d; logic [TW-1:0] t; logic [2:0] c;
        logic [AW-1:0] a; logic [BW-1:0] b; logic [DW-1:0] w;
        send(3'd0, 32'h1000, 4'hF, 0, r, d);
        check(r == 1, "R2 first attempt retried", r, 1);
        send(3'd0, 32'h1000, 4'hF, 0, r, d);
        check(r == 1, "R4 repeat before issue retried", r, 1);
        take(t, c, a, b, w);
        check(t == 0 && c == 0 && a == 32'h1000 && b == 4'hF, "R2 offered fields", {t, a}, 32'h1000);
        check(!tgt_req_valid, "R2 single offer", tgt_req_valid, 0);
        send(3'd0, 32'h1000, 4'hF, 0, r, d);
        check(r == 1, "R4 repeat while issued retried", r, 1);
        complete(t, 32'hCAFE0001);
        send(3'd0, 32'h1000, 4'hF, 0, r, d);
        check(r == 0 && d == 32'hCAFE0001, "R5 completed data returned", d, 32'hCAFE0001);
        send(3'd0, 32'h1000, 4'hF, 0, r, d);
        check(r == 1, "R5 entry freed, request new again", r, 1);
        take(t, c, a, b, w);
        check(a == 32'h1000, "R5 re-recorded request offered", a, 32'h1000);
        complete(t, 32'h5);
        send(3'd0, 32'h1000, 4'hF, 0, r, d);
        check(r == 0 && d == 32'h5, "R5 second fetch", d, 5);
    endtask

    // Full queue, round-robin issue, completions out of order.
    task automatic t_full_ooo();
        logic r; logic [DW-1:0] d; logic [TW-1:0] tg [4]; logic [2:0] c;
        logic [AW-1:0] ad [4]; logic [BW-1:0] b; logic [DW-1:0] w;
        for (int i = 0; i < 4; i++) send(3'd1, 32'h2000 + 32'(i * 4), 4'hF, 0, r, d);
        send(3'd2, 32'h9000, 4'hF, 0, r, d);
        check(r == 1, "R3 full queue retries new request", r, 1);
        for (int i = 0; i < 4; i++) take(tg[i], c, ad[i], b, w);
        for (int i = 1; i < 4; i++)
            check(tg[i] == tg[i-1] + 2'd1, "R8 round-robin order", tg[i], tg[i-1] + 2'd1);
        check(!tgt_req_valid, "R3 rejected request not recorded", tgt_req_valid, 0);
        complete(tg[3], 32'hD0 + ad[3]); complete(tg[1], 32'hD0 + ad[1]);
        complete(tg[0], 32'hD0 + ad[0]); complete(tg[2], 32'hD0 + ad[2]);
        for (int i = 0; i < 4; i++) begin
            send(3'd1, 32'h2000 + 32'(i * 4), 4'hF, 0, r, d);
            check(r == 0 && d == 32'hD0 + 32'h2000 + 32'(i * 4), "R7 out-of-order completion data",
                  d, 32'hD0 + 32'h2000 + 32'(i * 4));
        end
    endtask

    // Matching rules: read ignores wdata, byte enables must match.
    task automatic t_match();
        logic r; logic [DW-1:0] d; logic [TW-1:0] t; logic [2:0] c;
        logic [AW-1:0] a; logic [BW-1:0] b; logic [DW-1:0] w;
        send(3'd1, 32'h3000, 4'hF, 32'h11, r, d);
        send(3'd1, 32'h3000, 4'hF, 32'h22, r, d);
        send(3'd1, 32'h3000, 4'h1, 32'h11, r, d);
        take(t, c, a, b, w); complete(t, {28'h0, b});
        take(t, c, a, b, w); complete(t, {28'h0, b});
        check(!tgt_req_valid, "R6 read wdata not compared, two entries only", tgt_req_valid, 0);
        send(3'd1, 32'h3000, 4'hF, 32'h99, r, d);
        check(r == 0 && d == 32'hF, "R6 full-be read data", d, 32'hF);
        send(3'd1, 32'h3000, 4'h1, 32'h0, r, d);
        check(r == 0 && d == 32'h1, "R6 partial-be read separate entry", d, 1);
    endtask

    // Writes to the same address stay separate target requests.
    task automatic t_writes();
        logic r; logic [DW-1:0] d; logic [TW-1:0] t; logic [2:0] c;
        logic [AW-1:0] a; logic [BW-1:0] b; logic [DW-1:0] w; int seen;
        send(3'd3, 32'h4000, 4'h3, 32'h1111, r, d);
        send(3'd3, 32'h4000, 4'hC, 32'h2222, r, d);
        send(3'd3, 32'h4000, 4'h3, 32'h3333, r, d);
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            take(t, c, a, b, w);
            if (c == 3 && ((b == 4'h3 && w == 32'h1111) || (b == 4'hC && w == 32'h2222)
                           || (b == 4'h3 && w == 32'h3333))) seen = seen | (1 << i);
            complete(t, 32'h0);
        end
        check(seen == 7, "R9 three unmerged writes offered", seen, 7);
        check(!tgt_req_valid, "R9 no extra write offered", tgt_req_valid, 0);
        send(3'd3, 32'h4000, 4'hC, 32'h2222, r, d);
        check(r == 0, "R9 write status returned", r, 0);
        send(3'd3, 32'h4000, 4'h3, 32'h1111, r, d);
        send(3'd3, 32'h4000, 4'h3, 32'h3333, r, d);
        check(r == 0, "R9 second same-be write kept apart", r, 0);
    endtask

    // Completion and repeat of the same entry on the same edge.
    task automatic t_collide();
        logic r; logic [DW-1:0] d; logic [TW-1:0] t; logic [2:0] c;
        logic [AW-1:0] a; logic [BW-1:0] b; logic [DW-1:0] w;
        send(3'd4, 32'h5000, 4'hF, 32'h77, r, d);
        take(t, c, a, b, w);
        tgt_cpl_valid = 1; tgt_cpl_tag = t; tgt_cpl_data = 32'hBEEF;
        send(3'd4, 32'h5000, 4'hF, 32'h77, r, d);
        tgt_cpl_valid = 0;
        check(r == 1, "R4 repeat with simultaneous completion retried", r, 1);
        send(3'd4, 32'h5000, 4'hF, 32'h77, r, d);
        check(r == 0 && d == 32'hBEEF, "R5 data after collision", d, 32'hBEEF);
    endtask

    // Posted lanes: back-to-back beats, both directions at once.
    task automatic t_posted();
        dn_in_v = 1; dn_in_a = 32'h6000; dn_in_b = 4'h1; dn_in_d = 32'hA1;
        up_in_v = 1; up_in_a = 32'h7000; up_in_b = 4'h8; up_in_d = 32'hB1;
        @(negedge clk);
        check(dn_out_v && dn_out_a == 32'h6000 && dn_out_b == 4'h1 && dn_out_d == 32'hA1,
              "R10 downstream beat 1", dn_out_d, 32'hA1);
        check(up_out_v && up_out_a == 32'h7000 && up_out_b == 4'h8 && up_out_d == 32'hB1,
              "R11 upstream beat in same cycle", up_out_d, 32'hB1);
        dn_in_b = 4'h2; dn_in_d = 32'hA2; up_in_v = 0;
        @(negedge clk);
        dn_in_v = 0;
        check(dn_out_v && dn_out_a == 32'h6000 && dn_out_b == 4'h2 && dn_out_d == 32'hA2,
              "R10 same-address beat not collapsed", dn_out_d, 32'hA2);
        check(!up_out_v, "R11 upstream idle independently", up_out_v, 0);
        @(negedge clk);
        check(!dn_out_v, "R10 one output per input beat", dn_out_v, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_basic();
        t_full_ooo();
        t_match();
        t_writes();
        t_collide();
        t_posted();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule